// File: doc/BRIEF.md
# Pipelined 9/7 Lifting Wavelet Processor

This block computes the one-dimensional biorthogonal 9/7 wavelet transform on integer samples with the lifting method. An image row, widened by one mirrored column at its right edge, is cut into strips that overlap by one sample. Each clock cycle may carry one strip of 2P+1 samples. P parallel lanes run two predict steps, two update steps and two scaling steps through five register stages, and every lane emits one low-pass and one high-pass coefficient. All constant products are built from shifts and adds.

Strips of several image rows may be interleaved in any order, so long as the strips of each row arrive left to right. The partial results that the next strip of the same row needs are kept in three small memories, one word per row each. On the leftmost strip of a row the block does not read those memories. It takes mirrored in-strip values instead, which gives symmetric extension at the left image edge. Because a pair can only be finished once its right neighbours are known, lane k of strip s carries coefficient pair m = s*P + k - 1. On the leftmost strip, lane 0 is therefore marked not valid.

Top module: `dwtLift97`

## Requirements
- R1: A strip presented with `inValid` high in a cycle produces `outValid` high exactly five cycles later and in no other cycle. During and right after reset, `outValid`, `laneValid`, `lowOut` and `highOut` are all zero.
- R2: `sampIn` carries 2P+1 two's-complement samples of W bits (default W = 15, P = 2), with sample j at bits [j*W +: W]. Strip s of a row holds extended columns 2Ps to 2Ps+2P, so x[2m] is even and x[2m+1] is odd. With F(n,v) = floor(n*v/128), each step result below is truncated to W bits.
- R3: First predict: a(m) = x(2m+1) + F(-200, x(2m) + x(2m+2)).
- R4: First update: b(m) = x(2m) + F(-7, a(m-1) + a(m)), where a(-1) = a(0).
- R5: Second predict: c(m) = a(m) + F(113, b(m) + b(m+1)), where b(-1) = b(1).
- R6: Second update: d(m) = b(m) + F(57, c(m-1) + c(m)).
- R7: Scaling: the low output is F(146, d(m)) and the high output is F(111, c(m)). Lane k of the output for strip s holds pair m = s*P + k - 1, at bits [k*W +: W] of `lowOut` and `highOut`.
- R8: When the strip was marked `firstStrip`, bit 0 of `laneValid` is low and all other bits are high. For any other strip, all bits of `laneValid` are high. `laneValid` is zero whenever `outValid` is low.
- R9: A strip not marked `firstStrip` for row r uses the boundary partials left by the most recent strip of row r. Strips of other rows in between do not affect this.
- R10: Cycles with `inValid` low leave the boundary memories unchanged, and `lowOut` and `highOut` keep their values while `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A strip is presented this cycle |
| firstStrip | input | 1 | Presented strip is the leftmost of its row |
| rowIdx | input | RW | Row the strip belongs to (RW = clog2 of ROWS) |
| sampIn | input | (2P+1)*W | Strip samples, sample j at [j*W +: W] |
| outValid | output | 1 | Output coefficients present this cycle |
| laneValid | output | P | Per-lane validity of the output pair |
| lowOut | output | P*W | Low-pass coefficient per lane |
| highOut | output | P*W | High-pass coefficient per lane |

## Verification
The main function is driven with four row shapes: a linear ramp, a constant level, an alternating sign pattern and a scrambled sequence. The ramp and the constant reveal errors in the update and scaling terms, because the high band is nearly flat there. The alternating pattern drives the largest neighbour sums and shows sign and floor mistakes in the predict steps. The scrambled rows separate one lane from another and one row from another. Four rows are interleaved strip by strip, with idle gaps in some runs, so a wrong memory address or a write in an idle cycle corrupts the strip that follows. Every run starts with a leftmost strip while the memories still hold values from the previous run, which tests the mirrored boundary.

// File: rtl/dwtLiftPkg.sv
package dwtLiftPkg;

  // Fractional bits of every lifting and scaling constant.
  localparam int COEF_FRAC = 7;

  typedef enum logic [2:0] {
    CF_ALPHA,   // -200/128, first predict
    CF_BETA,    //   -7/128, first update
    CF_GAMMA,   //  113/128, second predict
    CF_DELTA,   //   57/128, second update
    CF_KLOW,    //  146/128, low-band scale
    CF_KHIGH    //  111/128, high-band scale
  } coefSelT;

  // Strobes from the control to the datapath, one bit per stage.
  typedef struct packed {
    logic [4:0] load;    // load[i]: stage i+1 registers capture
    logic [2:0] mirror;  // stages 2..4: use in-strip mirror, not the row memory
  } strobeT;

endpackage

// File: rtl/dwtLiftRowMem.sv
module dwtLiftRowMem #(
  parameter int W    = 15,
  parameter int ROWS = 4,
  parameter int RW   = 2
) (
  input  logic         clk,
  input  logic         we,
  input  logic [RW-1:0] addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wrData;
  end

  // Read the old word in the same cycle the new one is written.
  assign rdData = mem[addr];
endmodule

// File: rtl/dwtLiftCtrl.sv
module dwtLiftCtrl
  import dwtLiftPkg::*;
#(
  parameter int P  = 2,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          firstStrip,
  input  logic [RW-1:0] rowIdx,
  output strobeT        stb,
  output logic [RW-1:0] rowA,
  output logic [RW-1:0] rowB,
  output logic [RW-1:0] rowC,
  output logic          outValid,
  output logic [P-1:0]  laneValid
);
  logic [4:0]    vldQ;
  logic [4:0]    fstQ;
  logic [RW-1:0] rowQ [3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ    <= '0;
      fstQ    <= '0;
      rowQ[0] <= '0;
      rowQ[1] <= '0;
      rowQ[2] <= '0;
    end else begin
      vldQ    <= {vldQ[3:0], inValid};
      fstQ    <= {fstQ[3:0], firstStrip};
      rowQ[0] <= rowIdx;
      rowQ[1] <= rowQ[0];
      rowQ[2] <= rowQ[1];
    end
  end

  always_comb begin
    stb.load   = {vldQ[3:0], inValid};
    stb.mirror = fstQ[2:0];
  end

  assign rowA     = rowQ[0];
  assign rowB     = rowQ[1];
  assign rowC     = rowQ[2];
  assign outValid = vldQ[4];

  for (genvar k = 0; k < P; k++) begin : g_lane
    if (k == 0) begin : g_edge
      assign laneValid[k] = vldQ[4] & ~fstQ[4];
    end else begin : g_inner
      assign laneValid[k] = vldQ[4];
    end
  end
endmodule

// File: rtl/dwtLiftPath.sv
module dwtLiftPath
  import dwtLiftPkg::*;
#(
  parameter int P    = 2,
  parameter int W    = 15,
  parameter int ROWS = 4,
  parameter int RW   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [RW-1:0]      rowA,
  input  logic [RW-1:0]      rowB,
  input  logic [RW-1:0]      rowC,
  input  logic [(2*P+1)*W-1:0] sampIn,
  output logic [P*W-1:0]     lowOut,
  output logic [P*W-1:0]     highOut
);
  localparam int AW = W + 10;

  function automatic logic signed [W-1:0] mulShift(input logic signed [AW-1:0] v,
                                                   input coefSelT sel);
    logic signed [AW-1:0] p;
    case (sel)
      CF_ALPHA: p = -((v <<< 7) + (v <<< 6) + (v <<< 3));
      CF_BETA:  p = -((v <<< 3) - v);
      CF_GAMMA: p = (v <<< 7) - (v <<< 4) + v;
      CF_DELTA: p = (v <<< 6) - (v <<< 3) + v;
      CF_KLOW:  p = (v <<< 7) + (v <<< 4) + (v <<< 1);
      default:  p = (v <<< 7) - (v <<< 4) - v;
    endcase
    p = p >>> COEF_FRAC;
    return p[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] liftStep(input logic signed [W-1:0] base,
                                                   input logic signed [W-1:0] lft,
                                                   input logic signed [W-1:0] rgt,
                                                   input coefSelT sel);
    return base + mulShift(AW'(lft) + AW'(rgt), sel);
  endfunction

  logic signed [W-1:0] x  [2*P+1];
  logic signed [W-1:0] e1 [P+1];
  logic signed [W-1:0] a1 [P];
  logic signed [W-1:0] a2 [P];
  logic signed [W-1:0] b2 [P];
  logic signed [W-1:0] a2m;
  logic signed [W-1:0] b3 [P];
  logic signed [W-1:0] c3 [P];
  logic signed [W-1:0] d4 [P];
  logic signed [W-1:0] h4 [P];
  logic signed [W-1:0] loQ [P];
  logic signed [W-1:0] hiQ [P];
  logic signed [W-1:0] aPrev, bPrev, cPrev;
  logic [W-1:0] memARd, memBRd, memCRd;

  for (genvar j = 0; j < 2*P+1; j++) begin : g_unpack
    assign x[j] = sampIn[j*W +: W];
  end

  // Boundary partials: last first-predict, last first-update, last second-predict.
  dwtLiftRowMem #(.W(W), .ROWS(ROWS), .RW(RW)) u_memA (
    .clk(clk), .we(stb.load[1]), .addr(rowA), .wrData(a1[P-1]), .rdData(memARd));
  dwtLiftRowMem #(.W(W), .ROWS(ROWS), .RW(RW)) u_memB (
    .clk(clk), .we(stb.load[2]), .addr(rowB), .wrData(b2[P-1]), .rdData(memBRd));
  dwtLiftRowMem #(.W(W), .ROWS(ROWS), .RW(RW)) u_memC (
    .clk(clk), .we(stb.load[3]), .addr(rowC), .wrData(c3[P-1]), .rdData(memCRd));

  assign aPrev = stb.mirror[0] ? a1[0] : memARd;
  assign bPrev = stb.mirror[1] ? b2[1] : memBRd;
  assign cPrev = stb.mirror[2] ? c3[0] : memCRd;

  // Stage 1: first predict on every odd sample of the strip.
  always_ff @(posedge clk) begin
    if (stb.load[0]) e1[P] <= x[2*P];
  end

  // Stage 2 extra carry of the left boundary predict value.
  always_ff @(posedge clk) begin
    if (stb.load[1]) a2m <= aPrev;
  end

  for (genvar k = 0; k < P; k++) begin : g_lane
    logic signed [W-1:0] aLeft, aOld, bOld, cOld;
    if (k == 0) begin : g_edge
      assign aLeft = aPrev;
      assign aOld  = a2m;
      assign bOld  = bPrev;
      assign cOld  = cPrev;
    end else begin : g_inner
      assign aLeft = a1[k-1];
      assign aOld  = a2[k-1];
      assign bOld  = b2[k-1];
      assign cOld  = c3[k-1];
    end

    always_ff @(posedge clk) begin
      if (stb.load[0]) begin
        e1[k] <= x[2*k];
        a1[k] <= liftStep(x[2*k+1], x[2*k], x[2*k+2], CF_ALPHA);
      end
      if (stb.load[1]) begin
        a2[k] <= a1[k];
        b2[k] <= liftStep(e1[k], aLeft, a1[k], CF_BETA);
      end
      if (stb.load[2]) begin
        b3[k] <= bOld;
        c3[k] <= liftStep(aOld, bOld, b2[k], CF_GAMMA);
      end
      if (stb.load[3]) begin
        h4[k] <= c3[k];
        d4[k] <= liftStep(b3[k], cOld, c3[k], CF_DELTA);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ[k] <= '0;
        hiQ[k] <= '0;
      end else if (stb.load[4]) begin
        loQ[k] <= mulShift(AW'(d4[k]), CF_KLOW);
        hiQ[k] <= mulShift(AW'(h4[k]), CF_KHIGH);
      end
    end

    assign lowOut[k*W +: W]  = loQ[k];
    assign highOut[k*W +: W] = hiQ[k];
  end
endmodule

// File: rtl/dwtLift97.sv
module dwtLift97
  import dwtLiftPkg::*;
#(
  parameter int P    = 2,
  parameter int W    = 15,
  parameter int ROWS = 4,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 firstStrip,
  input  logic [RW-1:0]        rowIdx,
  input  logic [(2*P+1)*W-1:0] sampIn,
  output logic                 outValid,
  output logic [P-1:0]         laneValid,
  output logic [P*W-1:0]       lowOut,
  output logic [P*W-1:0]       highOut
);
  strobeT        stb;
  logic [RW-1:0] rowA, rowB, rowC;

  dwtLiftCtrl #(.P(P), .RW(RW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .firstStrip(firstStrip),
    .rowIdx(rowIdx), .stb(stb), .rowA(rowA), .rowB(rowB), .rowC(rowC),
    .outValid(outValid), .laneValid(laneValid));

  dwtLiftPath #(.P(P), .W(W), .ROWS(ROWS), .RW(RW)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .rowA(rowA), .rowB(rowB), .rowC(rowC),
    .sampIn(sampIn), .lowOut(lowOut), .highOut(highOut));
endmodule

// File: rtl/dwtLift97Chk.sv
module dwtLift97Chk #(
  parameter int P = 2,
  parameter int W = 15
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic           firstStrip,
  input logic           outValid,
  input logic [P-1:0]   laneValid,
  input logic [P*W-1:0] lowOut,
  input logic [P*W-1:0] highOut
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd5) sinceRst <= sinceRst + 3'd1;
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd5) |-> (outValid == $past(inValid, 5))); // R1

  AST_NO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (laneValid == '0)); // R8

  AST_INNER_LANES: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (&laneValid[P-1:1])); // R8

  AST_EDGE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd5 && outValid && $past(firstStrip, 5)) |-> !laneValid[0]); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(lowOut) && $stable(highOut))); // R10
endmodule

bind dwtLift97 dwtLift97Chk #(.P(P), .W(W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .firstStrip(firstStrip),
  .outValid(outValid), .laneValid(laneValid), .lowOut(lowOut), .highOut(highOut));

// File: tb/dwtLift97_bench.sv
`timescale 1ns/1ps
module dwtLift97_bench;
  localparam int P      = 2;
  localparam int W      = 15;
  localparam int ROWS   = 4;
  localparam int RW     = 2;
  localparam int NCOL   = 12;
  localparam int STRIPS = 4;
  localparam int XL     = 2*P*STRIPS + 1;
  localparam int NPAIR  = P*STRIPS;
  localparam int NPAT   = 4;
  // {shape, amplitude/seed, idle cycles after each strip}
  localparam int PAT [NPAT][3] = '{'{0, 9, 0}, '{1, -120, 1}, '{2, 150, 0}, '{3, 7, 2}};

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 firstStrip = 1'b0;
  logic [RW-1:0]        rowIdx = '0;
  logic [(2*P+1)*W-1:0] sampIn = '0;
  logic                 outValid;
  logic [P-1:0]         laneValid;
  logic [P*W-1:0]       lowOut, highOut;

  int nChecks = 0;
  int nFail   = 0;
  int xe    [ROWS][XL];
  int expLo [ROWS][NPAIR];
  int expHi [ROWS][NPAIR];

  always #10 clk = ~clk;

  dwtLift97 #(.P(P), .W(W), .ROWS(ROWS)) u_dwtLift97 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .firstStrip(firstStrip),
    .rowIdx(rowIdx), .sampIn(sampIn), .outValid(outValid), .laneValid(laneValid),
    .lowOut(lowOut), .highOut(highOut));

  function automatic int fl(int n, int v);
    return (n * v) >>> 7;
  endfunction

  function automatic int sample(int kind, int amp, int r, int col);
    case (kind)
      0:       return col * amp + r * 5;
      1:       return amp + r;
      2:       return ((col % 2) != 0 ? -amp : amp) + r * 3;
      default: return ((col * 37 + r * 53 + amp * 11) % 401) - 200;
    endcase
  endfunction

  // Reference transform from R3..R7 on the mirrored row.
  task automatic buildRef(int kind, int amp);
    int a [NPAIR];
    int b [NPAIR];
    int cc [NPAIR];
    int d;
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < XL; i++)
        xe[r][i] = sample(kind, amp, r, (i < NCOL) ? i : 2*(NCOL-1) - i);
      for (int m = 0; m < NPAIR; m++)
        a[m] = xe[r][2*m+1] + fl(-200, xe[r][2*m] + xe[r][2*m+2]);
      for (int m = 0; m < NPAIR; m++)
        b[m] = xe[r][2*m] + fl(-7, ((m == 0) ? a[0] : a[m-1]) + a[m]);
      cc[0] = a[0] + fl(113, b[1] + b[0]);
      for (int m = 0; m < NPAIR-1; m++)
        cc[m+1] = a[m] + fl(113, b[m] + b[m+1]);
      for (int m = 0; m < NPAIR-1; m++) begin
        d = b[m] + fl(57, cc[m] + cc[m+1]);
        expLo[r][m] = fl(146, d);
        expHi[r][m] = fl(111, cc[m+1]);
      end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendStrip(int r, int s);
    inValid    = 1'b1;
    firstStrip = (s == 0);
    rowIdx     = RW'(r);
    for (int j = 0; j < 2*P+1; j++)
      sampIn[j*W +: W] = W'(xe[r][2*P*s + j]);
    @(negedge clk);
  endtask

  task automatic checkOutput(int r, int s, string tag);
    int m;
    chk({tag, " R8 laneValid"}, int'(laneValid), (s == 0) ? ((1 << P) - 2) : ((1 << P) - 1));
    for (int k = 0; k < P; k++) begin
      m = s*P + k - 1;
      if (m >= 0) begin
        chk({tag, " R2/R3/R4/R6/R7 low"}, int'($signed(lowOut[k*W +: W])), expLo[r][m]);
        chk({tag, " R3/R4/R5/R7 high"}, int'($signed(highOut[k*W +: W])), expHi[r][m]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [P*W-1:0] loHeld, hiHeld;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset outValid", int'(outValid), 0);
    chk("R1 reset laneValid", int'(laneValid), 0);
    chk("R1 reset lowOut", int'(lowOut), 0);
    chk("R1 reset highOut", int'(highOut), 0);

    // R1: five-cycle latency of a single leftmost strip
    buildRef(0, 9);
    sendStrip(0, 0);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 not yet valid", int'(outValid), 0);
    @(negedge clk);
    chk("R1 valid after five cycles", int'(outValid), 1);
    checkOutput(0, 0, "latency");
    @(negedge clk);
    chk("R1 single pulse", int'(outValid), 0);
    loHeld = lowOut;
    hiHeld = highOut;
    repeat (3) @(negedge clk);
    chk("R10 low held while idle", int'(lowOut == loHeld), 1);
    chk("R10 high held while idle", int'(highOut == hiHeld), 1);

    // Main table: rows interleaved per strip (R9), optional idle gaps (R10)
    for (int p = 0; p < NPAT; p++) begin
      buildRef(PAT[p][0], PAT[p][1]);
      fork
        begin
          for (int s = 0; s < STRIPS; s++)
            for (int r = 0; r < ROWS; r++) begin
              sendStrip(r, s);
              if (PAT[p][2] > 0) begin
                inValid = 1'b0;
                repeat (PAT[p][2]) @(negedge clk);
              end
            end
          inValid = 1'b0;
        end
        begin
          for (int k = 0; k < STRIPS*ROWS; k++) begin
            @(negedge clk);
            while (!outValid) @(negedge clk);
            checkOutput(k % ROWS, k / ROWS, $sformatf("R9 pattern %0d", p));
          end
        end
      join
      repeat (6) @(negedge clk);
      chk("R1 drained", int'(outValid), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule